// File: doc/BRIEF.md
# Multi-Mode Count-Up Timer with One-Shot Pulse-Width Capture

This block is an 8-bit up-counter that has three ways to advance. It can count edges of an external input pin. It can count ticks of a divided system clock. It can measure, once, how long the pin stays high or low. Software reaches it through a small register bus with three addresses: a shared data address, a control address and an overflow-flag address. A write to the data address sets a hidden reload value. A read of the same address returns the live count.

The external pin is passed through a two-flop synchroniser before any edge is detected. When the count steps past its all-ones value, it reloads from the hidden reload value. In the same edge it raises a sticky overflow flag and a one-cycle wake pulse. The interrupt request is the flag gated by an enable input.

In measurement mode the block arms when software sets the run bit. It starts counting at a start edge and stops at the opposite edge. It then clears its own run bit and keeps the result until software arms it again.

Top module: `pulse_timer`

## Requirements
- R1: A write to address 0 loads only the hidden reload register and leaves the live count unchanged. A read of address 0 returns the live count. After reset the count, reload value, control register and flag are all 0.
- R2: When the mode field (control bits 7:6) is 00 or the run bit (control bit 4) is 0, the count holds and pin edges are ignored.
- R3: In mode 10 the count advances once every 2^(p+1) clocks, where p is control bits 2:0. The first step comes 2^(p+1) clocks after the control write that starts it.
- R4: In mode 01 the count advances once per synchronised pin edge. Control bit 3 = 0 selects rising edges and bit 3 = 1 selects falling edges.
- R5: A step taken while the count is all ones loads the reload value. In the same edge it sets the overflow flag and drives a one-clock wake pulse.
- R6: In mode 11 with bit 3 = 1, the block measures the high time (start on a rising edge, stop on the falling edge). With bit 3 = 0 it measures the low time. The prescaler restarts at the start edge. A level held for L clocks adds floor(L / 2^(p+1)) to the count.
- R7: Measurement is edge-triggered. If the run bit is set while the pin is already at the active level, the return edge is ignored and counting waits for a fresh start edge.
- R8: In mode 11 hardware clears the run bit when a measurement ends. In modes 01 and 10 only a control write clears it.
- R9: After a measurement the count is held and further pin edges are ignored until a control write sets the run bit again.
- R10: The irq output equals the overflow flag AND irq_en. The flag is recorded whatever irq_en is.
- R11: Reading address 1 returns the control register as written: bits 7:6 mode, bit 4 run, bit 3 edge select, bits 2:0 prescale. Bit 5 always reads 0.
- R12: Address 2 reads the flag in bit 0. Any write to address 2 clears the flag. An overflow on the same edge as the clear wins, so the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address: 0 data, 1 control, 2 flag |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data for bus_addr (combinational) |
| ext_pin | input | 1 | Asynchronous external input |
| irq_en | input | 1 | Interrupt request enable |
| irq | output | 1 | Overflow interrupt request |
| wake | output | 1 | One-clock pulse on every overflow |

## Verification
Timer mode is run with random prescale codes, random run lengths and reload values near all ones. This checks the division ratio, the start alignment and reload-on-overflow, including the extra step on the stopping edge. Event mode is driven with random pulse trains that end with the pin high, so rising-edge and falling-edge selection give different counts. Pulse-width mode is driven with random widths, both polarities and several prescale codes. A second pulse after each measurement shows the hold. A directed arming at the active level shows that capture is triggered by edges, not levels. A directed case where every step overflows places a flag clear on the overflow edge to show that the overflow takes priority.

// File: rtl/pulse_timer_pkg.sv
package pulse_timer_pkg;

    localparam int CTRL_W = 8;
    localparam int PSC_W  = 3;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] ADDR_DATA = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_FLAG = 2'd2;

    typedef enum logic [1:0] {
        MODE_OFF   = 2'b00,
        MODE_EVENT = 2'b01,
        MODE_TIMER = 2'b10,
        MODE_PULSE = 2'b11
    } mode_e;

    // Packed MSB first: mode[7:6], rsv[5], run[4], edge_sel[3], psc[2:0]
    typedef struct packed {
        mode_e            mode;
        logic             rsv;
        logic             run;
        logic             edge_sel;
        logic [PSC_W-1:0] psc;
    } ctrl_t;

endpackage

// File: rtl/pt_pin_sync.sv
module pt_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);
    typedef struct packed {
        logic [STAGES-1:0] sh;
        logic              prev;
    } sync_t;

    sync_t s_q, s_d;

    always_comb begin
        s_d      = s_q;
        s_d.sh   = {s_q.sh[STAGES-2:0], pin};
        s_d.prev = s_q.sh[STAGES-1];
        rise     = s_q.sh[STAGES-1] & ~s_q.prev;
        fall     = ~s_q.sh[STAGES-1] & s_q.prev;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/pt_prescaler.sv
module pt_prescaler #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int DIV_W = 1 << SEL_W;
    localparam logic [DIV_W:0]   SPAN_ONE = (DIV_W+1)'(1);
    localparam logic [DIV_W-1:0] DIV_ONE  = DIV_W'(1);
    localparam logic [SEL_W:0]   SEL_ONE  = (SEL_W+1)'(1);

    logic [DIV_W-1:0] div_q, div_d;
    logic [DIV_W:0]   span;
    logic [DIV_W:0]   span_m1;
    logic [DIV_W-1:0] mask;

    always_comb begin
        span    = SPAN_ONE << ({1'b0, sel} + SEL_ONE);
        span_m1 = span - SPAN_ONE;
        mask    = span_m1[DIV_W-1:0];
        tick    = ((div_q & mask) == mask);
        div_d   = clr ? '0 : div_q + DIV_ONE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    // R3: a restart is never followed directly by a tick
    a_r3_no_tick_after_clr: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !tick);
    // R3: ticks are at least two clocks apart
    a_r3_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/pt_count_core.sv
module pt_count_core
    import pulse_timer_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_data,
    input  logic             wr_ctrl,
    input  logic             wr_flag,
    input  logic [CNT_W-1:0] wdata,
    input  logic             rise,
    input  logic             fall,
    input  logic             tick,
    output logic [CNT_W-1:0] count,
    output ctrl_t            ctrl,
    output logic             flag,
    output logic             wake,
    output logic             psc_clr
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic [CNT_W-1:0] preload;
        ctrl_t            ctrl;
        logic             flag;
        logic             wake;
        logic             meas;
    } core_t;

    core_t s_q, s_d;
    logic  start_edge, stop_edge, inc;

    always_comb begin
        s_d        = s_q;
        s_d.wake   = 1'b0;
        start_edge = s_q.ctrl.edge_sel ? rise : fall;
        stop_edge  = s_q.ctrl.edge_sel ? fall : rise;
        inc        = 1'b0;
        psc_clr    = wr_ctrl;

        if (s_q.ctrl.run) begin
            case (s_q.ctrl.mode)
                MODE_EVENT: inc = s_q.ctrl.edge_sel ? fall : rise;
                MODE_TIMER: inc = tick;
                MODE_PULSE: begin
                    if (s_q.meas) begin
                        inc = tick;
                        if (stop_edge) begin
                            s_d.meas     = 1'b0;
                            s_d.ctrl.run = 1'b0;
                        end
                    end else if (start_edge) begin
                        s_d.meas = 1'b1;
                        psc_clr  = 1'b1;
                    end
                end
                default: inc = 1'b0;
            endcase
        end

        if (wr_flag) s_d.flag = 1'b0;

        if (inc) begin
            if (s_q.count == CNT_MAX) begin
                s_d.count = s_q.preload;
                s_d.flag  = 1'b1;
                s_d.wake  = 1'b1;
            end else begin
                s_d.count = s_q.count + CNT_ONE;
            end
        end

        if (wr_data) s_d.preload = wdata;

        if (wr_ctrl) begin
            s_d.ctrl     = ctrl_t'(wdata[CTRL_W-1:0]);
            s_d.ctrl.rsv = 1'b0;
            s_d.meas     = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign count = s_q.count;
    assign ctrl  = s_q.ctrl;
    assign flag  = s_q.flag;
    assign wake  = s_q.wake;

    // R2: stopped or idle mode keeps the count
    a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ctrl.mode == MODE_OFF || !s_q.ctrl.run) |=> $stable(s_q.count));
    // R5: wake pulse comes with a set flag
    a_r5_wake_flag: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.wake |-> s_q.flag);
    // R5: overflow lands on the reload value
    a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.wake |-> (s_q.count == $past(s_q.preload)));
    // R8: outside measurement mode only software drops the run bit
    a_r8_run_sw_only: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(s_q.ctrl.run) && ($past(s_q.ctrl.mode) != MODE_PULSE)) |-> $past(wr_ctrl));
    // R8: end of a measurement leaves the run bit cleared
    a_r8_hw_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(s_q.meas) && !s_q.meas && !$past(wr_ctrl)) |-> !s_q.ctrl.run);
    // R9: armed-or-done measurement mode does not move the count
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ctrl.mode == MODE_PULSE && !s_q.meas) |=> $stable(s_q.count));
    // R12: a clear without a coinciding overflow empties the flag
    a_r12_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_flag) && !s_q.wake) |-> !s_q.flag);

endmodule

// File: rtl/pulse_timer.sv
module pulse_timer
    import pulse_timer_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    input  logic              ext_pin,
    input  logic              irq_en,
    output logic              irq,
    output logic              wake
);
    logic             wr_data, wr_ctrl, wr_flag;
    logic             rise, fall, tick, psc_clr, flag;
    logic [CNT_W-1:0] count;
    ctrl_t            ctrl;

    assign wr_data = bus_wr && (bus_addr == ADDR_DATA);
    assign wr_ctrl = bus_wr && (bus_addr == ADDR_CTRL);
    assign wr_flag = bus_wr && (bus_addr == ADDR_FLAG);

    pt_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  (ext_pin),
        .rise (rise),
        .fall (fall)
    );

    pt_prescaler #(.SEL_W(PSC_W)) u_psc (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (psc_clr),
        .sel  (ctrl.psc),
        .tick (tick)
    );

    pt_count_core #(.CNT_W(CNT_W)) u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_data(wr_data),
        .wr_ctrl(wr_ctrl),
        .wr_flag(wr_flag),
        .wdata  (bus_wdata),
        .rise   (rise),
        .fall   (fall),
        .tick   (tick),
        .count  (count),
        .ctrl   (ctrl),
        .flag   (flag),
        .wake   (wake),
        .psc_clr(psc_clr)
    );

    always_comb begin
        case (bus_addr)
            ADDR_DATA: bus_rdata = count;
            ADDR_CTRL: bus_rdata = CNT_W'(ctrl);
            ADDR_FLAG: bus_rdata = CNT_W'(flag);
            default:   bus_rdata = '0;
        endcase
        irq = flag & irq_en;
    end

    // R10: a disabled request never reaches the output
    a_r10_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);
    // R10: an enabled, recorded flag is forwarded
    a_r10_gate_on: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en && flag) |-> irq);

endmodule

// File: tb/pulse_timer_tb.sv
`timescale 1ns/100ps
module pulse_timer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       ext_pin = 1'b0;
    logic       irq_en = 1'b0;
    logic       irq, wake;

    int checks = 0, fails = 0, wake_seen = 0, exp_wake = 0;
    logic exp_flag = 1'b0;
    logic [7:0] preload_m = 8'd0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pulse_timer u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_pin(ext_pin),
        .irq_en(irq_en), .irq(irq), .wake(wake)
    );

    always @(negedge clk) if (rst_n && wake) wake_seen++;

    function automatic logic [7:0] f_adv(logic [7:0] v, logic [7:0] p, int n);
        for (int i = 0; i < n; i++) v = (v == 8'hFF) ? p : v + 8'd1;
        return v;
    endfunction

    function automatic int f_ovf(logic [7:0] v, logic [7:0] p, int n);
        int o = 0;
        for (int i = 0; i < n; i++) begin
            if (v == 8'hFF) begin v = p; o++; end
            else v = v + 8'd1;
        end
        return o;
    endfunction

    function automatic logic [7:0] f_ctrl(logic [1:0] m, logic run, logic es, int p);
        return {m, 1'b0, run, es, 3'(p)};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [7:0] v);
        bus_addr = a;
        #0.1;
        v = bus_rdata;
    endtask

    task automatic account(logic [7:0] st, int n);
        int o = f_ovf(st, preload_m, n);
        exp_wake += o;
        if (o > 0) exp_flag = 1'b1;
    endtask

    task automatic run_timer(int p, int n_wait, logic [7:0] pre);
        logic [7:0] st, v;
        int ninc;
        wr(2'd0, pre); preload_m = pre;
        rd(2'd0, st);
        wr(2'd1, f_ctrl(2'b10, 1'b1, 1'b0, p));
        idle(n_wait);
        wr(2'd1, f_ctrl(2'b10, 1'b0, 1'b0, p));
        ninc = (n_wait + 1) / (2 << p);
        account(st, ninc);
        rd(2'd0, v);
        chk("R3 timer count", v, f_adv(st, preload_m, ninc));
        rd(2'd1, v);
        chk("R8 timer run kept until write", v[4], 1'b0);
        idle(2);
        chk("R5 wake pulse total", wake_seen, exp_wake);
        rd(2'd2, v);
        chk("R5 flag", v[0], exp_flag);
        irq_en = 1'($urandom % 2);
        #0.1;
        chk("R10 irq gate", irq, exp_flag & irq_en);
    endtask

    task automatic run_event(logic es, int npulse);
        logic [7:0] st, v;
        int n;
        ext_pin = 1'b0; idle(6);
        rd(2'd0, st);
        wr(2'd1, f_ctrl(2'b01, 1'b1, es, 0));
        idle(3);
        for (int i = 0; i < npulse; i++) begin
            ext_pin = 1'b1; idle(2 + $urandom % 4);
            ext_pin = 1'b0; idle(2 + $urandom % 4);
        end
        ext_pin = 1'b1; idle(6);
        rd(2'd1, v);
        chk("R8 event run kept", v[4], 1'b1);
        wr(2'd1, f_ctrl(2'b01, 1'b0, es, 0));
        n = es ? npulse : npulse + 1;
        account(st, n);
        rd(2'd0, v);
        chk(es ? "R4 falling edges" : "R4 rising edges", v, f_adv(st, preload_m, n));
        st = v;
        ext_pin = 1'b0; idle(6);
        rd(2'd0, v);
        chk("R2 stopped ignores pin", v, st);
    endtask

    task automatic run_pulse(logic es, int p, int len);
        logic [7:0] st, v;
        int n;
        ext_pin = ~es; idle(6);
        rd(2'd0, st);
        wr(2'd1, f_ctrl(2'b11, 1'b1, es, p));
        idle(4);
        ext_pin = es;  idle(len);
        ext_pin = ~es; idle(6);
        n = len / (2 << p);
        account(st, n);
        rd(2'd0, v);
        chk(es ? "R6 high width" : "R6 low width", v, f_adv(st, preload_m, n));
        st = v;
        rd(2'd1, v);
        chk("R8 run cleared by hardware", v[4], 1'b0);
        ext_pin = es;  idle(len + 3);
        ext_pin = ~es; idle(6);
        rd(2'd0, v);
        chk("R9 result held", v, st);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog all-requirements actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] v, st;
        int sd;
        sd = $urandom(32'd715);
        idle(4);
        rst_n = 1'b1;
        idle(2);

        // R1 / R11 / R12 reset state
        rd(2'd0, v); chk("R1 reset count", v, 8'h00);
        rd(2'd1, v); chk("R11 reset control", v, 8'h00);
        rd(2'd2, v); chk("R12 reset flag", v, 8'h00);
        chk("R10 reset irq", irq, 1'b0);

        // R1: data write only sets reload
        wr(2'd0, 8'h3C); preload_m = 8'h3C;
        rd(2'd0, v); chk("R1 write keeps count", v, 8'h00);

        // R11: bit 5 reads 0
        wr(2'd1, 8'hE5);
        rd(2'd1, v); chk("R11 control readback", v, 8'hC5);
        rd(2'd3, v); chk("R12 unused address", v, 8'h00);

        // R2: mode 00 with run set stays idle
        wr(2'd1, f_ctrl(2'b00, 1'b1, 1'b0, 0));
        idle(20);
        ext_pin = 1'b1; idle(5); ext_pin = 1'b0; idle(5);
        rd(2'd0, v); chk("R2 mode 00 idle", v, 8'h00);
        wr(2'd1, 8'h00);

        for (int it = 0; it < 14; it++) begin
            case ($urandom % 3)
                0: run_timer($urandom % 3, 20 + $urandom % 380, 8'hF0 | 8'($urandom % 16));
                1: run_event(1'($urandom % 2), 1 + $urandom % 8);
                default: run_pulse(1'($urandom % 2), $urandom % 4, 3 + $urandom % 100);
            endcase
        end
        run_event(1'b0, 3);
        run_event(1'b1, 3);
        run_pulse(1'b1, 0, 17);
        run_pulse(1'b0, 2, 45);

        // R7: armed while at the active level
        ext_pin = 1'b1; idle(6);
        rd(2'd0, st);
        wr(2'd1, f_ctrl(2'b11, 1'b1, 1'b1, 0));
        idle(5);
        ext_pin = 1'b0; idle(6);
        rd(2'd0, v); chk("R7 level at arming not counted", v, st);
        rd(2'd1, v); chk("R8 run stays armed", v[4], 1'b1);
        ext_pin = 1'b1; idle(10); ext_pin = 1'b0; idle(6);
        account(st, 5);
        rd(2'd0, v); chk("R7 fresh edge measured", v, f_adv(st, preload_m, 5));

        // R12: every step overflows with reload FF; clear on an overflow edge
        run_timer(0, 600, 8'hFF);
        rd(2'd0, v); chk("R5 reload all ones", v, 8'hFF);
        wr(2'd1, f_ctrl(2'b10, 1'b1, 1'b0, 0));
        idle(1);
        wr(2'd2, 8'h00);
        wr(2'd1, f_ctrl(2'b10, 1'b0, 1'b0, 0));
        exp_wake += 1; exp_flag = 1'b1;
        rd(2'd2, v); chk("R12 overflow beats clear", v[0], 1'b1);
        irq_en = 1'b0; #0.1;
        chk("R10 disabled irq", irq, 1'b0);
        rd(2'd2, v); chk("R10 flag still recorded", v[0], 1'b1);
        irq_en = 1'b1; #0.1;
        chk("R10 enabled irq", irq, 1'b1);
        wr(2'd2, 8'h00); exp_flag = 1'b0;
        rd(2'd2, v); chk("R12 flag cleared", v[0], 1'b0);
        chk("R12 irq after clear", irq, 1'b0);
        idle(3);
        chk("R5 wake pulse final", wake_seen, exp_wake);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule